// File: doc/BRIEF.md
# Key-Protected DRAM Controller Configuration Registers

This block is the control-space register file of a DRAM controller. Software reaches it over a simple 32-bit register bus with a setup phase and an access phase, inside a 4 KiB address window. Every access is one full 32-bit word, and the word index is the byte address shifted right by two. Word 0 is a guard register. Storing the correct 32-bit key there opens the block. Storing any other value closes it again. While the block is closed, writes to every other word are thrown away.

Word 1 holds the controller configuration. Some of its fields are fixed by hardware, and a write never changes them. Which fields are fixed depends on the silicon-revision parameter. The value the configuration word takes at reset is built from the same revision parameter and from a memory-size parameter, which is turned into a two-bit size code. The remaining implemented words are plain storage. A one-cycle error pulse reports a write refused by the lock and any access outside the implemented words. This block does no DRAM sequencing. The configuration bits only name those functions.

Top module: `dramctl_cfg_regs`

## Requirements
- R1: After reset, word 0 reads 0 (closed), word 1 reads its seeded reset value, and every other implemented word reads 0.
- R2: A write of exactly 0xFC600309 to word 0 makes word 0 read 1 (open). A write of any other value to word 0 makes it read 0 (closed). Word 0 accepts writes whether the block is open or closed.
- R3: While word 0 reads 0, a write to any other implemented word leaves that word unchanged and raises the error pulse.
- R4: With REV=0, bits 31:11, bit 6 and bits 3:2 of word 1 keep their value across any write. All other bits of word 1 take the written value.
- R5: With REV=1, bits 31:28, 19:14, bit 6 and bits 3:2 of word 1 keep their value across any write. All other bits of word 1 take the written value.
- R6: Reset value of word 1: with REV=0 it is bit 6 set plus the size code in bits 1:0. With REV=1 it is 1 in bits 31:28, 3 in bits 3:2 and the size code in bits 1:0.
- R7: Size code with REV=0: 64, 128, 256 and 512 MB give codes 0, 1, 2 and 3, and any other size gives code 2 (256 MB). With REV=1: 128, 256, 512 and 1024 MB give codes 0, 1, 2 and 3, and any other size gives code 2 (512 MB).
- R8: A read of a word index at or above NUM_WORDS returns 0. A write there changes no word and does not change the lock. Both raise the error pulse.
- R9: While the block is open, words 2 to NUM_WORDS-1 store and return any 32-bit value.
- R10: A write takes effect at the clock edge that ends its access phase. Read data is valid during the access phase with no wait states. The error pulse is high for exactly the one cycle after the offending access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Block selected (setup and access phases) |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in a read access phase |
| err_o | output | 1 | One-cycle error pulse after a refused or out-of-range access |

## Verification
The hardest case to reach from the ports is a write to the configuration word while the block is open, with data that sets and clears bits both inside and outside the fixed fields. The fixed fields must survive, while the neighbouring writable bits change in the same write. A wrong key stored between such writes must also close the block partway through a sequence. The stimulus mixes random writes and reads with frequent good-key and bad-key writes to word 0. The block therefore flips between open and closed many times, and word 1 receives random data in both states. Directed cases add all-ones and all-zeros writes to word 1 and accesses at the top of the window. Three instances with different revision and size parameters share one bus, so each mask and each reset seed is checked under the same traffic.

// File: rtl/dramctl_cfg_pkg.sv
`timescale 1ns/1ps
package dramctl_cfg_pkg;

   localparam int unsigned WORD_W = 32;
   localparam logic [WORD_W-1:0] OPEN_KEY = 32'hFC60_0309;

   // Word roles that other logic decodes
   localparam int unsigned GUARD_IDX = 0;
   localparam int unsigned CFG_IDX   = 1;

   // Revision selector values
   localparam int REV_A = 0;
   localparam int REV_B = 1;

   // Fixed-field pieces shared by both revisions
   localparam logic [WORD_W-1:0] FLD_LEGACY_DISP = 32'h0000_0040; // bit 6
   localparam logic [WORD_W-1:0] FLD_APERTURE    = 32'h0000_000C; // bits 3:2
   // Revision A
   localparam logic [WORD_W-1:0] FLD_A_UPPER     = 32'hFFFF_F800; // 31:11
   // Revision B
   localparam logic [WORD_W-1:0] FLD_B_HWVER     = 32'hF000_0000; // 31:28
   localparam logic [WORD_W-1:0] FLD_B_INITDONE  = 32'h0008_0000; // 19
   localparam logic [WORD_W-1:0] FLD_B_SPARE     = 32'h0007_C000; // 18:14

   function automatic logic [WORD_W-1:0] fixed_mask(int rev);
      logic [WORD_W-1:0] m;
      m = FLD_LEGACY_DISP | FLD_APERTURE;
      if (rev == REV_A) m = m | FLD_A_UPPER;
      else              m = m | FLD_B_HWVER | FLD_B_INITDONE | FLD_B_SPARE;
      return m;
   endfunction

   function automatic logic [1:0] size_code(int rev, int mb);
      logic [1:0] c;
      c = 2'd2;  // fallback: 256 MB for A, 512 MB for B
      if (rev == REV_A) begin
         case (mb)
            64:      c = 2'd0;
            128:     c = 2'd1;
            256:     c = 2'd2;
            512:     c = 2'd3;
            default: c = 2'd2;
         endcase
      end else begin
         case (mb)
            128:     c = 2'd0;
            256:     c = 2'd1;
            512:     c = 2'd2;
            1024:    c = 2'd3;
            default: c = 2'd2;
         endcase
      end
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] cfg_seed(int rev, int mb);
      logic [WORD_W-1:0] v;
      v = {30'd0, size_code(rev, mb)};
      if (rev == REV_A) v = v | FLD_LEGACY_DISP;
      else              v = v | 32'h1000_0000 | FLD_APERTURE;
      return v;
   endfunction

endpackage

// File: rtl/dramctl_cfg_decode.sv
`timescale 1ns/1ps
module dramctl_cfg_decode #(
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned NUM_WORDS = 16
) (
   input  logic [IDX_W-1:0]     idx,
   output logic                 in_range,
   output logic [NUM_WORDS-1:0] hit
);
   assign in_range = ({22'd0, idx} < NUM_WORDS);

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_hit
      assign hit[i] = ({22'd0, idx} == i);
   end
endmodule

// File: rtl/dramctl_cfg_lock.sv
`timescale 1ns/1ps
module dramctl_cfg_lock
   import dramctl_cfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output logic              open_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  open_q <= 1'b0;
      else if (we) open_q <= (wdata == OPEN_KEY);
   end
endmodule

// File: rtl/dramctl_cfg_word.sv
`timescale 1ns/1ps
module dramctl_cfg_word
   import dramctl_cfg_pkg::*;
#(
   parameter logic [WORD_W-1:0] RST_VAL  = '0,
   parameter logic [WORD_W-1:0] FIX_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= (q & FIX_MASK) | (wdata & ~FIX_MASK);
   end
endmodule

// File: rtl/dramctl_cfg_regs.sv
`timescale 1ns/1ps
module dramctl_cfg_regs
   import dramctl_cfg_pkg::*;
#(
   parameter int REV       = 0,
   parameter int MEM_MB    = 256,
   parameter int NUM_WORDS = 16,
   parameter int ADDR_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              err_o
);
   localparam int IDX_W = ADDR_W - 2;
   localparam int SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam logic [WORD_W-1:0] SEED = cfg_seed(REV, MEM_MB);
   localparam logic [WORD_W-1:0] MASK = fixed_mask(REV);

   // Elaboration checks
   if (REV != REV_A && REV != REV_B) begin : g_bad_rev
      $error("dramctl_cfg_regs: REV must be 0 or 1");
   end
   if (NUM_WORDS < 2 || NUM_WORDS > (1 << IDX_W)) begin : g_bad_words
      $error("dramctl_cfg_regs: NUM_WORDS out of range for the window");
   end
   if (ADDR_W != 12) begin : g_bad_addr
      $error("dramctl_cfg_regs: window is 4 KiB, ADDR_W must be 12");
   end

   logic [IDX_W-1:0]     idx;
   logic                 in_range;
   logic [NUM_WORDS-1:0] hit;
   logic                 acc, wr_acc;
   logic                 open_q;
   logic [WORD_W-1:0]    words [NUM_WORDS];
   logic [WORD_W-1:0]    cfg_q;
   logic                 err_d;
   logic                 unused_lsb;

   assign idx        = paddr[ADDR_W-1:2];
   assign unused_lsb = ^paddr[1:0];
   assign acc        = psel & penable;
   assign wr_acc     = acc & pwrite & in_range;

   dramctl_cfg_decode #(.IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)) u_dec (
      .idx      (idx),
      .in_range (in_range),
      .hit      (hit)
   );

   dramctl_cfg_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_acc & hit[GUARD_IDX]),
      .wdata  (pwdata),
      .open_q (open_q)
   );

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      if (i == GUARD_IDX) begin : g_guard
         assign words[i] = {{(WORD_W-1){1'b0}}, open_q};
      end else begin : g_store
         dramctl_cfg_word #(
            .RST_VAL  ((i == CFG_IDX) ? SEED : '0),
            .FIX_MASK ((i == CFG_IDX) ? MASK : '0)
         ) u_w (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_acc & open_q & hit[i]),
            .wdata (pwdata),
            .q     (words[i])
         );
      end
   end

   assign cfg_q  = words[CFG_IDX];
   assign prdata = (acc && !pwrite && in_range) ? words[idx[SEL_W-1:0]] : '0;

   assign err_d = acc & (~in_range | (pwrite & ~hit[GUARD_IDX] & ~open_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_o <= 1'b0;
      else        err_o <= err_d;
   end
endmodule

// File: rtl/dramctl_cfg_regs_chk.sv
`timescale 1ns/1ps
module dramctl_cfg_regs_chk
   import dramctl_cfg_pkg::*;
#(
   parameter int REV       = 0,
   parameter int NUM_WORDS = 16,
   parameter int ADDR_W    = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       pwdata,
   input logic [31:0]       prdata,
   input logic              err_o,
   input logic              open_q,
   input logic [31:0]       cfg_q
);
   localparam logic [31:0] MASK = fixed_mask(REV);

   logic acc, in_rng, is_guard;
   assign acc      = psel & penable;
   assign in_rng   = ({22'd0, paddr[ADDR_W-1:2]} < NUM_WORDS);
   assign is_guard = (paddr[ADDR_W-1:2] == '0);

   // R2: the right key opens
   p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && pwrite && is_guard && pwdata == OPEN_KEY |=> open_q);
   // R2: any other value closes
   p_bad_key_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && pwrite && is_guard && pwdata != OPEN_KEY |=> !open_q);
   // R2: guard word reads back the lock state
   p_guard_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !pwrite && is_guard |-> prdata == {31'd0, open_q});
   // R3: refused write flagged
   p_locked_write_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && pwrite && in_rng && !is_guard && !open_q |=> err_o);
   // R3: configuration held while closed
   p_locked_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !open_q |=> $stable(cfg_q));
   // R4 / R5: fixed fields never move
   p_fixed_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cfg_q & MASK));
   // R8: out-of-range read returns zero
   p_oor_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !pwrite && !in_rng |-> prdata == 32'd0);
   // R8: out-of-range access flagged, lock untouched
   p_oor_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !in_rng |=> err_o && $stable(open_q));
   // R10: error is a single-cycle pulse
   p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);
endmodule

bind dramctl_cfg_regs dramctl_cfg_regs_chk #(
   .REV(REV), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .err_o(err_o),
   .open_q(open_q), .cfg_q(cfg_q)
);

// File: tb/dramctl_cfg_regs_tb.sv
`timescale 1ns/1ps
module dramctl_cfg_regs_tb;
   localparam int NW = 16;
   localparam logic [31:0] KEY  = 32'hFC60_0309;
   localparam logic [31:0] RO_A = 32'hFFFF_F84C; // 31:11, 6, 3:2
   localparam logic [31:0] RO_B = 32'hF00F_C04C; // 31:28, 19:14, 6, 3:2

   logic clk = 1'b0, rst_n = 1'b0;
   logic psel = 0, penable = 0, pwrite = 0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] rd_a, rd_b, rd_c;
   logic err_a, err_b, err_c;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] ma [NW];
   logic [31:0] mb [NW];
   logic [31:0] mc [NW];
   bit lock_open = 0;

   always #2.5 clk = ~clk;

   // A: rev 0, 128 MB -> code 1. B: rev 1, 300 MB -> fallback code 2. C: rev 0, 1000 MB -> fallback code 2.
   dramctl_cfg_regs #(.REV(0), .MEM_MB(128), .NUM_WORDS(NW)) u_dut (
      .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata(rd_a), .err_o(err_a));
   dramctl_cfg_regs #(.REV(1), .MEM_MB(300), .NUM_WORDS(NW)) u_dut_b (
      .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata(rd_b), .err_o(err_b));
   dramctl_cfg_regs #(.REV(0), .MEM_MB(1000), .NUM_WORDS(NW)) u_dut_c (
      .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata(rd_c), .err_o(err_c));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [31:0] m);
      return (old & m) | (d & ~m);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NW; i++) begin ma[i] = 0; mb[i] = 0; mc[i] = 0; end
      ma[1] = 32'h0000_0041;   // R6/R7 rev A, 128 MB
      mb[1] = 32'h1000_000E;   // R6/R7 rev B, fallback 512 MB
      mc[1] = 32'h0000_0042;   // R6/R7 rev A, fallback 256 MB
      lock_open = 0;
   endtask

   task automatic access(bit wr, int idx, logic [31:0] d, string req);
      bit inr = (idx < NW);
      bit exp_err;
      @(negedge clk);
      chk("R10 err low between accesses", {29'd0, err_a, err_b, err_c}, 32'd0);
      psel = 1; penable = 0; pwrite = wr; paddr = 12'(idx * 4); pwdata = d;
      @(negedge clk);
      penable = 1;
      #1;
      if (!wr) begin
         chk({req, " rdA"}, rd_a, inr ? ma[idx] : 32'd0);
         chk({req, " rdB"}, rd_b, inr ? mb[idx] : 32'd0);
         chk({req, " rdC"}, rd_c, inr ? mc[idx] : 32'd0);
      end
      exp_err = !inr || (wr && idx != 0 && !lock_open);
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
      chk({req, " R10 err pulse"}, {29'd0, err_a, err_b, err_c}, exp_err ? 32'd7 : 32'd0);
      if (wr && inr) begin
         if (idx == 0) begin
            lock_open = (d == KEY);
            ma[0] = {31'd0, lock_open}; mb[0] = ma[0]; mc[0] = ma[0];
         end else if (lock_open) begin
            if (idx == 1) begin
               ma[1] = merge(ma[1], d, RO_A);
               mb[1] = merge(mb[1], d, RO_B);
               mc[1] = merge(mc[1], d, RO_A);
            end else begin
               ma[idx] = d; mb[idx] = d; mc[idx] = d;
            end
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 / R6 / R7 reset state
      for (int i = 0; i < NW; i++) access(0, i, 0, "R1 reset read");
      // R3 locked writes dropped
      access(1, 1, 32'hFFFF_FFFF, "R3 locked cfg write");
      access(1, 5, 32'hDEAD_BEEF, "R3 locked word write");
      access(0, 1, 0, "R3 cfg unchanged");
      access(0, 5, 0, "R3 word unchanged");
      // R2 unlock, readback
      access(1, 0, KEY, "R2 key");
      access(0, 0, 0, "R2 open reads 1");
      // R4 / R5 masking with all ones, then all zeros
      access(1, 1, 32'hFFFF_FFFF, "R4 R5 cfg ones");
      access(0, 1, 0, "R4 R5 cfg ones read");
      access(1, 1, 32'h0000_0000, "R4 R5 cfg zeros");
      access(0, 1, 0, "R4 R5 cfg zeros read");
      // R9 plain words, R10 read right after write
      access(1, NW - 1, 32'hA5A5_5A5A, "R9 last word");
      access(0, NW - 1, 0, "R9 R10 last word read");
      // R8 out of range, top of window
      access(1, 1023, 32'h1234_5678, "R8 oor write");
      access(0, 1023, 0, "R8 oor read");
      access(0, NW, 0, "R8 first oor read");
      access(0, 0, 0, "R8 lock kept");
      // R2 near-miss key relocks
      access(1, 0, KEY ^ 32'h1, "R2 bad key");
      access(0, 0, 0, "R2 closed reads 0");
      access(1, 2, 32'h1111_1111, "R3 after relock");
      access(0, 2, 0, "R3 after relock read");
      // Random traffic
      for (int n = 0; n < 600; n++) begin
         int sel = $urandom_range(0, 99);
         int idx = $urandom_range(0, NW + 3);
         logic [31:0] d = $urandom();
         if (sel < 15)      access(1, 0, KEY, "R2 rnd key");
         else if (sel < 20) access(1, 0, d, "R2 rnd bad key");
         else if (sel < 35) access(1, 1, d, "R4 R5 rnd cfg write");
         else if (sel < 60) access(1, idx, d, "R9 R3 R8 rnd write");
         else               access(0, idx, 0, "R9 R4 R5 rnd read");
      end
      access(0, 1, 0, "R4 R5 final cfg");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule